// File: doc/BRIEF.md
# PHY Management Register Engine

This block turns one host write of a 32-bit control word into a complete serial management transaction with an external PHY. The host packs the whole request into the word: an opcode, a 5-bit PHY address, a 5-bit register address and, for a write, 16 bits of data. The engine then drives a management clock and data line through a 64-bit frame. On a read it captures the PHY's 16 data bits into the low half of the word. When the frame ends it raises a ready flag and, if enabled, pulses an interrupt request.

The host polls the ready bit or waits for the interrupt, then reads the control word back to obtain the result. Only one transaction is in flight at a time. A control word that selects both opcodes or neither completes at once without touching the serial line.

The frame state machine walks through five named states. IDLE leaves MDC low and the line undriven. PRE drives 32 ones. HDR shifts 14 header bits: start 01, opcode, PHY address, register address. TA covers the 2-bit turnaround. DATA moves 16 data bits. The transitions are:

- IDLE to PRE on an accepted valid write of the control word.
- PRE to HDR at the 32nd falling MDC edge.
- HDR to TA at the 14th falling MDC edge.
- TA to DATA at the 2nd falling MDC edge.
- DATA to IDLE at the 16th falling MDC edge, which also issues the internal completion pulse.

Top module: `phy_mgmt_engine`

## Requirements
- R1: After reset the control word reads 0x10000000 (only the ready flag, bit 28, set), MDC is low, the line is not driven and the interrupt request is low.
- R2: A control word with bit 26 set and bit 27 clear produces a write frame, MSB first, with the line driven throughout. The frame is 32 ones, then 01, then opcode 01, then the PHY address from bits 25:21, then the register address from bits 20:16, then turnaround 10, then data bits 15:0.
- R3: A control word with bit 27 set and bit 26 clear produces a read frame. It carries opcode 10 and the same preamble, start and address fields as a write. The line is released (enable low) for the 2 turnaround bits and the 16 data bits.
- R4: On a read, the line is sampled at each rising MDC edge of the data phase and shifted MSB first into bits 15:0. At frame end the ready flag is set. The other fields, including bits 31:30 and the interrupt-enable bit 29, read back as written.
- R5: The ready flag is low from the accepted write until the frame ends. A control word write while a frame is in progress is ignored: the fields do not change and no extra frame is produced.
- R6: A control word with both or neither of bits 27:26 set is accepted with ready set on the next cycle, and MDC never toggles.
- R7: The interrupt request pulses for exactly one cycle on completion (including the immediate completion of R6) when bit 29 of the accepted word was set, and stays low otherwise.
- R8: Each frame bit spans one MDC period of 2*HALF_DIV clock cycles, low half first, and a frame is exactly 64 periods. The ready flag becomes visible 128*HALF_DIV+1 clock edges after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word written by the host |
| cfg_rdata | output | 32 | Current control word (ready flag, fields, read data) |
| mgmt_irq | output | 1 | One-cycle completion interrupt request |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data returned by the PHY |

## Verification
A wrong frame state or bit counter shows up on the serial line within one MDC period. The bench records every bit at the rising MDC edge, together with its drive enable, so a misplaced field, a missing turnaround release or a wrong MDC count is caught in the frame the fault occurs. A wrong control state shows at cfg_rdata by the next polling cycle: ready rising early or late, fields changing during a frame, or read data arriving shifted. The exact completion latency of R8 pins any extra or missing register stage to a single cycle.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int HDR_LEN   = 2 + 2 + 2 * ADDR_W;
    localparam int TA_LEN    = 2;
    localparam int FRAME_LEN = PRE_LEN + HDR_LEN + TA_LEN + DATA_W;

    // control word bit positions
    localparam int BIT_WR    = 26;
    localparam int BIT_RD    = 27;
    localparam int BIT_RDY   = 28;
    localparam int BIT_IE    = 29;
    localparam int PHY_LSB   = 21;
    localparam int REG_LSB   = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA
    } mgmt_state_t;

endpackage

// File: rtl/phy_mgmt_tick.sv
module phy_mgmt_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_cnt_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/phy_mgmt_frame.sv
module phy_mgmt_frame
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);
    mgmt_state_t       state_q, state_d;
    logic [4:0]        bit_q;
    logic [HDR_LEN-1:0] hdr_q;
    logic [DATA_W-1:0] data_q;
    logic              rd_q;
    logic              mdc_q;
    logic              fall, rise, leave;

    assign fall  = tick && mdc_q;
    assign rise  = tick && !mdc_q;
    assign leave = (state_d != state_q);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)                                      state_d = ST_PRE;
            ST_PRE:  if (fall && bit_q == 5'(PRE_LEN - 1))           state_d = ST_HDR;
            ST_HDR:  if (fall && bit_q == 5'(HDR_LEN - 1))           state_d = ST_TA;
            ST_TA:   if (fall && bit_q == 5'(TA_LEN - 1))            state_d = ST_DATA;
            ST_DATA: if (fall && bit_q == 5'(DATA_W - 1))            state_d = ST_IDLE;
            default:                                                 state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            hdr_q  <= '0;
            data_q <= '0;
            rd_q   <= 1'b0;
            mdc_q  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= (state_q == ST_DATA) && (state_d == ST_IDLE);
            if (state_q == ST_IDLE) begin
                mdc_q <= 1'b0;
                bit_q <= '0;
                if (start) begin
                    hdr_q  <= {2'b01, (start_rd ? 2'b10 : 2'b01), phy_addr, reg_addr};
                    data_q <= wdata;
                    rd_q   <= start_rd;
                end
            end else begin
                if (tick) mdc_q <= ~mdc_q;
                if (rise && state_q == ST_DATA && rd_q)
                    data_q <= {data_q[DATA_W-2:0], mdio_i};
                if (fall) begin
                    bit_q <= leave ? '0 : bit_q + 1'b1;
                    if (state_q == ST_HDR)
                        hdr_q <= {hdr_q[HDR_LEN-2:0], 1'b0};
                    if (state_q == ST_DATA && !rd_q)
                        data_q <= {data_q[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    // outputs
    always_comb begin
        mdio_o  = 1'b1;
        mdio_oe = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b0;
            end
            ST_PRE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_HDR: begin
                mdio_o  = hdr_q[HDR_LEN-1];
                mdio_oe = 1'b1;
            end
            ST_TA: begin
                mdio_o  = (bit_q == 5'd0);
                mdio_oe = !rd_q;
            end
            ST_DATA: begin
                mdio_o  = data_q[DATA_W-1];
                mdio_oe = !rd_q;
            end
            default: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b0;
            end
        endcase
    end

    assign busy  = (state_q != ST_IDLE);
    assign mdc   = mdc_q;
    assign rdata = data_q;

    assert_mdc_low_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !mdc_q);

    assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state_q == ST_IDLE));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_release_after_hdr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_HDR && state_q == ST_TA && rd_q) |-> !mdio_oe);

endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] rdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              start,
    output logic              start_rd,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] wdata,
    output logic              irq
);
    logic [1:0]        spare_q;
    logic              ie_q, rdy_q, rd_q, wr_q;
    logic [ADDR_W-1:0] phy_q, reg_q;
    logic [DATA_W-1:0] data_q;
    logic              accept, valid_op;

    assign accept   = cfg_we && !busy;
    assign valid_op = cfg_wdata[BIT_RD] ^ cfg_wdata[BIT_WR];
    assign start    = accept && valid_op;
    assign start_rd = cfg_wdata[BIT_RD];
    assign phy_addr = cfg_wdata[PHY_LSB +: ADDR_W];
    assign reg_addr = cfg_wdata[REG_LSB +: ADDR_W];
    assign wdata    = cfg_wdata[DATA_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spare_q <= '0;
            ie_q    <= 1'b0;
            rdy_q   <= 1'b1;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            phy_q   <= '0;
            reg_q   <= '0;
            data_q  <= '0;
            irq     <= 1'b0;
        end else if (accept) begin
            spare_q <= cfg_wdata[WORD_W-1:BIT_IE+1];
            ie_q    <= cfg_wdata[BIT_IE];
            rd_q    <= cfg_wdata[BIT_RD];
            wr_q    <= cfg_wdata[BIT_WR];
            phy_q   <= phy_addr;
            reg_q   <= reg_addr;
            data_q  <= wdata;
            rdy_q   <= !valid_op;
            irq     <= !valid_op && cfg_wdata[BIT_IE];
        end else if (done) begin
            rdy_q <= 1'b1;
            irq   <= ie_q;
            if (rd_q) data_q <= rdata;
        end else begin
            irq <= 1'b0;
        end
    end

    assign cfg_rdata = {spare_q, ie_q, rdy_q, rd_q, wr_q, phy_q, reg_q, data_q};

    assert_busy_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rdy_q);

    assert_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we) |=> ($stable(phy_q) && $stable(reg_q) && $stable(data_q) && $stable(ie_q)));

    assert_done_sets_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_we) |=> rdy_q);

    assert_irq_needs_ie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie_q);

endmodule

// File: rtl/phy_mgmt_engine.sv
module phy_mgmt_engine
    import phy_mgmt_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              mgmt_irq,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic              busy, done, tick, start, start_rd;
    logic [ADDR_W-1:0] phy_addr, reg_addr;
    logic [DATA_W-1:0] wdata, rdata;

    phy_mgmt_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .cfg_rdata (cfg_rdata),
        .start     (start),
        .start_rd  (start_rd),
        .phy_addr  (phy_addr),
        .reg_addr  (reg_addr),
        .wdata     (wdata),
        .irq       (mgmt_irq)
    );

    phy_mgmt_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    phy_mgmt_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .start_rd (start_rd),
        .phy_addr (phy_addr),
        .reg_addr (reg_addr),
        .wdata    (wdata),
        .tick     (tick),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .rdata    (rdata),
        .mdc      (mdc),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    assert_mdc_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy);

endmodule

// File: tb/phy_mgmt_engine_tb.sv
module phy_mgmt_engine_tb_top;

    localparam int HALF = 4;
    localparam int LATENCY = 128 * HALF + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mgmt_irq, mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int failures = 0;
    int fall_raw = 0;
    int rise_raw = 0;
    int irq_raw = 0;
    int fall_base = 0;
    int bit_idx;
    logic [63:0] cap_o = '0;
    logic [63:0] cap_oe = '0;
    logic [15:0] resp = 16'h0000;
    bit finished = 0;

    always #4 clk = ~clk;

    phy_mgmt_engine #(.HALF_DIV(HALF)) dut_i (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata), .mgmt_irq (mgmt_irq), .mdc (mdc),
        .mdio_o (mdio_o), .mdio_oe (mdio_oe), .mdio_i (mdio_i)
    );

    // PHY model
    assign bit_idx = fall_raw - fall_base;
    always_comb begin
        if (bit_idx >= 48 && bit_idx < 64) mdio_i = resp[63 - bit_idx];
        else                               mdio_i = 1'b1;
    end
    always @(negedge mdc) fall_raw = fall_raw + 1;
    always @(posedge mdc) begin
        rise_raw = rise_raw + 1;
        if (bit_idx >= 0 && bit_idx < 64) begin
            cap_o[63 - bit_idx]  = mdio_o;
            cap_oe[63 - bit_idx] = mdio_oe;
        end
    end
    always @(negedge clk) if (mgmt_irq) irq_raw = irq_raw + 1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit ie, input bit rd, input bit wr,
                                       input logic [4:0] pa, input logic [4:0] ra,
                                       input logic [15:0] d);
        return {2'b00, ie, 1'b0, rd, wr, pa, ra, d};
    endfunction

    task automatic issue(input logic [31:0] w, input bit new_frame);
        @(negedge clk);
        cfg_wdata = w;
        cfg_we = 1'b1;
        if (new_frame) begin
            fall_base = fall_raw;
            cap_o = '0;
            cap_oe = '0;
        end
    endtask

    task automatic wait_ready(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cfg_we = 1'b0;
            cyc++;
        end while (!cfg_rdata[28] && cyc < 5000);
    endtask

    task automatic t_reset;
        check(cfg_rdata == 32'h1000_0000, "R1 word", cfg_rdata, 32'h1000_0000);
        check(mdc == 1'b0, "R1 mdc", mdc, 0);
        check(mdio_oe == 1'b0, "R1 oe", mdio_oe, 0);
        check(mgmt_irq == 1'b0, "R1 irq", mgmt_irq, 0);
    endtask

    task automatic t_write;
        logic [31:0] w;
        logic [63:0] exp;
        int cyc, irq0;
        w = mk(1'b1, 1'b0, 1'b1, 5'h0A, 5'h03, 16'hBEEF);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0A, 5'h03, 2'b10, 16'hBEEF};
        irq0 = irq_raw;
        issue(w, 1'b1);
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_rdata[28] == 1'b0, "R5 ready low during write frame", cfg_rdata, 0);
        wait_ready(cyc);
        cyc = cyc + 1;
        check(cap_o == exp, "R2 write frame bits", cap_o, exp);
        check(cap_oe == '1, "R2 write frame driven", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
        check(bit_idx == 64, "R8 write frame periods", bit_idx, 64);
        check(cyc == LATENCY, "R8 completion latency", cyc, LATENCY);
        check(cfg_rdata == (w | 32'h1000_0000), "R4 write readback", cfg_rdata, w | 32'h1000_0000);
        repeat (3) @(negedge clk);
        check(irq_raw - irq0 == 1, "R7 irq pulse with enable", irq_raw - irq0, 1);
    endtask

    task automatic t_read;
        logic [31:0] w, expw;
        logic [63:0] exp;
        int cyc, irq0;
        w = mk(1'b0, 1'b1, 1'b0, 5'h1F, 5'h11, 16'h0000);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h1F, 5'h11, 18'h0};
        resp = 16'hA5C3;
        irq0 = irq_raw;
        issue(w, 1'b1);
        wait_ready(cyc);
        check(cap_o[63:18] == exp[63:18], "R3 read header bits", cap_o[63:18], exp[63:18]);
        check(cap_oe == {{46{1'b1}}, 18'h0}, "R3 read line release", cap_oe, {{46{1'b1}}, 18'h0});
        expw = {2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 5'h1F, 5'h11, 16'hA5C3};
        check(cfg_rdata == expw, "R4 read data captured", cfg_rdata, expw);
        repeat (3) @(negedge clk);
        check(irq_raw == irq0, "R7 no irq without enable", irq_raw - irq0, 0);
        resp = 16'h3C5A;
        w = {2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 5'h01, 5'h02, 16'hFFFF};
        issue(w, 1'b1);
        wait_ready(cyc);
        expw = {2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 5'h01, 5'h02, 16'h3C5A};
        check(cfg_rdata == expw, "R4 second read data and spare bits", cfg_rdata, expw);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] a, b;
        logic [63:0] exp;
        int cyc;
        a = mk(1'b0, 1'b0, 1'b1, 5'h05, 5'h1E, 16'h1234);
        b = mk(1'b1, 1'b1, 1'b0, 5'h16, 5'h07, 16'hCAFE);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h05, 5'h1E, 2'b10, 16'h1234};
        issue(a, 1'b1);
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (60) @(negedge clk);
        issue(b, 1'b0);
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_rdata == a, "R5 busy write ignored fields", cfg_rdata, a);
        wait_ready(cyc);
        check(cap_o == exp, "R5 frame unchanged by busy write", cap_o, exp);
        repeat (40) @(negedge clk);
        check(bit_idx == 64, "R5 no extra frame", bit_idx, 64);
        check(cfg_rdata == (a | 32'h1000_0000), "R5 word after busy write", cfg_rdata, a | 32'h1000_0000);
    endtask

    task automatic t_invalid;
        logic [31:0] w;
        int cyc, r0, irq0;
        r0 = rise_raw;
        irq0 = irq_raw;
        w = mk(1'b1, 1'b1, 1'b1, 5'h02, 5'h04, 16'h5555);
        issue(w, 1'b1);
        wait_ready(cyc);
        check(cyc == 1, "R6 both opcodes immediate ready", cyc, 1);
        repeat (20) @(negedge clk);
        check(irq_raw - irq0 == 1, "R7 irq on immediate completion", irq_raw - irq0, 1);
        w = mk(1'b0, 1'b0, 1'b0, 5'h03, 5'h05, 16'hAAAA);
        issue(w, 1'b1);
        wait_ready(cyc);
        check(cyc == 1, "R6 no opcode immediate ready", cyc, 1);
        repeat (20) @(negedge clk);
        check(rise_raw == r0, "R6 mdc idle", rise_raw - r0, 0);
        check(irq_raw - irq0 == 1, "R7 no irq for disabled immediate", irq_raw - irq0, 1);
        check(cfg_rdata == (w | 32'h1000_0000), "R6 word readback", cfg_rdata, w | 32'h1000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_busy_ignore();
        t_invalid();
        t_write();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule